// File: doc/BRIEF.md
# Link Input Error Recovery Controller

This block is the receive-side protocol state machine of a serial packet link. Each cycle it takes one set of status flags from the receive datapath. These are a packet-complete strobe with the packet's ackID, priority and error flags, a buffer-available bit for each priority, and single-cycle events for decoded control symbols and link-level violations. From these it decides whether to accept the packet, ask the partner to retry it, or reject it and start error recovery. It then asks the transmit side to emit the matching control symbol.

The controller has three states: normal, retry-stopped and error-stopped. A buffer shortage leads to retry-stopped, and a restart-from-retry symbol is the only way back to normal. Any packet or link violation leads to error-stopped. Recovery from error-stopped goes in a fixed order: packet-not-accepted is requested on entry, the controller waits for a link-request/input-status, and it then requests a link-response carrying the next expected ackID. If no link-request arrives within a programmable number of cycles, a sticky unrecoverable-error flag is raised. A one-cycle event on each entry to error-stopped is meant to set an external sticky input-error status bit.

Top module: `link_rx_recovery`

## Requirements
- R1: After reset the controller is in normal state: retry_stopped, error_stopped, fatal_err and all request pulses are 0, and the expected ackID (seen on lresp_ackid) is 0.
- R2: In normal state, a pkt_valid packet with no error flag, pkt_ackid equal to the expected ackID and buf_avail[pkt_prio]=1 gives pkt_accept=1 for exactly one cycle after the sampling edge. It also advances the expected ackID by one modulo 64 (6-bit ackID), wrapping 63 to 0.
- R3: In normal state, an error-free packet with the expected ackID and buf_avail[pkt_prio]=0 gives one send_retry pulse and sets retry_stopped. The controller leaves retry-stopped only on rfr_rcvd, and is normal from the cycle after that edge.
- R4: In normal state, a pkt_valid packet with pkt_crc_err, pkt_bad_char, pkt_too_long or a pkt_ackid different from the expected value gives one send_pna pulse and sets error_stopped. This check takes precedence over the buffer check.
- R5: In normal state, any of cs_crc_err, idle_bad_char, cancel_by_rfr, ack_bad_id or ack_timeout, with or without a packet, gives one send_pna pulse and sets error_stopped.
- R6: In error-stopped, lreq_rcvd gives one send_lresp pulse with lresp_ackid equal to the expected ackID, and the controller returns to normal in the same cycle.
- R7: If no lreq_rcvd is sampled on any of the LREQ_TIMEOUT edges after entry to error-stopped, fatal_err is set on the last of them. It stays 1 until reset, and a later lreq_rcvd still completes recovery.
- R8: In either stopped state a pkt_valid packet is discarded: no pkt_accept, no send_retry, and the expected ackID does not change.
- R9: In retry-stopped a link violation (R5 list) moves the controller to error-stopped with send_pna, and wins over an rfr_rcvd in the same cycle. In error-stopped further violations produce no second send_pna or err_event.
- R10: err_event is a one-cycle pulse raised together with send_pna, only on entry to error-stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A received packet is complete this cycle |
| pkt_ackid | input | 6 | ackID of the packet |
| pkt_prio | input | 2 | Priority of the packet |
| pkt_crc_err | input | 1 | Packet CRC check failed |
| pkt_bad_char | input | 1 | Invalid or non-data character inside the packet |
| pkt_too_long | input | 1 | Payload exceeded the maximum size |
| buf_avail | input | 4 | Buffer space available, one bit per priority |
| cs_crc_err | input | 1 | Control symbol CRC error |
| idle_bad_char | input | 1 | Invalid character or one not allowed in an idle sequence |
| cancel_by_rfr | input | 1 | Packet cancelled by restart-from-retry |
| ack_bad_id | input | 1 | Acknowledgment with an unexpected ackID |
| ack_timeout | input | 1 | Timeout waiting for an acknowledgment |
| rfr_rcvd | input | 1 | Restart-from-retry symbol received |
| lreq_rcvd | input | 1 | Link-request/input-status symbol received |
| pkt_accept | output | 1 | Request packet-accepted for the packet |
| send_retry | output | 1 | Request a packet-retry symbol |
| send_pna | output | 1 | Request a packet-not-accepted symbol |
| send_lresp | output | 1 | Request a link-response symbol |
| lresp_ackid | output | 6 | Expected ackID, carried by the link-response |
| err_event | output | 1 | One-cycle input-error event |
| retry_stopped | output | 1 | Controller is retry-stopped |
| error_stopped | output | 1 | Controller is error-stopped |
| fatal_err | output | 1 | Sticky unrecoverable error |

## Verification
The embedded properties take every event input to be a single-cycle strobe sampled at the rising edge, with pkt_ackid, pkt_prio and buf_avail meaningful only while pkt_valid is high. They assume nothing about which events arrive together, so packets, violations, restart-from-retry and link-request may arrive in the same cycle. The stimulus changes inputs only on the falling edge. Its random phase draws ackIDs mostly equal to the model's expected value and sometimes wrong, and mixes rare violations with frequent restart and link-request events so that every state is entered and left many times, including timeouts.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_RETRY_STOP = 2'd1,
    ST_ERR_STOP   = 2'd2
  } rx_state_e;

endpackage

// File: rtl/rx_violation_detect.sv
module rx_violation_detect #(
  parameter int ACKID_W  = 6,
  parameter int NUM_PRIO = 4,
  localparam int PRIO_W  = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
  input  logic                pkt_valid,
  input  logic [ACKID_W-1:0]  pkt_ackid,
  input  logic [PRIO_W-1:0]   pkt_prio,
  input  logic [ACKID_W-1:0]  exp_ackid,
  input  logic                pkt_crc_err,
  input  logic                pkt_bad_char,
  input  logic                pkt_too_long,
  input  logic [NUM_PRIO-1:0] buf_avail,
  input  logic                cs_crc_err,
  input  logic                idle_bad_char,
  input  logic                cancel_by_rfr,
  input  logic                ack_bad_id,
  input  logic                ack_timeout,
  output logic                pkt_violation,
  output logic                link_violation,
  output logic                buf_ok
);

  logic [2:0] pkt_flags;
  logic [4:0] link_flags;
  logic       ackid_bad;

  assign pkt_flags  = {pkt_crc_err, pkt_bad_char, pkt_too_long};
  assign link_flags = {cs_crc_err, idle_bad_char, cancel_by_rfr, ack_bad_id, ack_timeout};
  assign ackid_bad  = (pkt_ackid != exp_ackid);

  always_comb begin
    pkt_violation  = pkt_valid && ((|pkt_flags) || ackid_bad);
    link_violation = |link_flags;
  end

  // per-priority buffer select, one term per priority
  logic [NUM_PRIO-1:0] prio_hit;
  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
    assign prio_hit[p] = (pkt_prio == PRIO_W'(p)) && buf_avail[p];
  end
  assign buf_ok = |prio_hit;

endmodule

// File: rtl/rx_ackid_tracker.sv
module rx_ackid_tracker #(
  parameter int ACKID_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  output logic [ACKID_W-1:0] exp_ackid
);

  logic [ACKID_W-1:0] exp_q;
  logic [ACKID_W-1:0] exp_d;

  always_comb begin
    exp_d = exp_q + ACKID_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
    end else if (advance) begin
      exp_q <= exp_d;
    end
  end

  assign exp_ackid = exp_q;

  AST_ACKID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(advance) |-> $stable(exp_q)); // R8

endmodule

// File: rtl/rx_lreq_timer.sv
module rx_lreq_timer #(
  parameter int LREQ_TIMEOUT = 16,
  localparam int CNT_W = (LREQ_TIMEOUT > 1) ? $clog2(LREQ_TIMEOUT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic fatal
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fatal_q, fatal_d;
  logic             at_limit;
  logic             expire;

  assign at_limit = (cnt_q == CNT_W'(LREQ_TIMEOUT - 1));
  assign expire   = tick && at_limit;

  always_comb begin
    cnt_d   = cnt_q;
    fatal_d = fatal_q | expire;
    if (clear) begin
      cnt_d = '0;
    end else if (tick && !at_limit) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fatal_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fatal_q <= fatal_d;
    end
  end

  assign fatal = fatal_q;

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LREQ_TIMEOUT - 1)); // R7

endmodule

// File: rtl/link_rx_recovery.sv
module link_rx_recovery
  import link_rx_pkg::*;
#(
  parameter int ACKID_W      = 6,
  parameter int NUM_PRIO     = 4,
  parameter int LREQ_TIMEOUT = 16,
  localparam int PRIO_W      = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_valid,
  input  logic [ACKID_W-1:0]  pkt_ackid,
  input  logic [PRIO_W-1:0]   pkt_prio,
  input  logic                pkt_crc_err,
  input  logic                pkt_bad_char,
  input  logic                pkt_too_long,
  input  logic [NUM_PRIO-1:0] buf_avail,
  input  logic                cs_crc_err,
  input  logic                idle_bad_char,
  input  logic                cancel_by_rfr,
  input  logic                ack_bad_id,
  input  logic                ack_timeout,
  input  logic                rfr_rcvd,
  input  logic                lreq_rcvd,
  output logic                pkt_accept,
  output logic                send_retry,
  output logic                send_pna,
  output logic                send_lresp,
  output logic [ACKID_W-1:0]  lresp_ackid,
  output logic                err_event,
  output logic                retry_stopped,
  output logic                error_stopped,
  output logic                fatal_err
);

  rx_state_e          state_q, state_d;
  logic [ACKID_W-1:0] exp_ackid;
  logic               pkt_violation, link_violation, buf_ok;
  logic               acc_d, rty_d, pna_d, lresp_d, evt_d;
  logic               acc_q, rty_q, pna_q, lresp_q, evt_q;
  logic               timer_tick;

  rx_violation_detect #(
    .ACKID_W  (ACKID_W),
    .NUM_PRIO (NUM_PRIO)
  ) i_detect (
    .pkt_valid      (pkt_valid),
    .pkt_ackid      (pkt_ackid),
    .pkt_prio       (pkt_prio),
    .exp_ackid      (exp_ackid),
    .pkt_crc_err    (pkt_crc_err),
    .pkt_bad_char   (pkt_bad_char),
    .pkt_too_long   (pkt_too_long),
    .buf_avail      (buf_avail),
    .cs_crc_err     (cs_crc_err),
    .idle_bad_char  (idle_bad_char),
    .cancel_by_rfr  (cancel_by_rfr),
    .ack_bad_id     (ack_bad_id),
    .ack_timeout    (ack_timeout),
    .pkt_violation  (pkt_violation),
    .link_violation (link_violation),
    .buf_ok         (buf_ok)
  );

  rx_ackid_tracker #(
    .ACKID_W (ACKID_W)
  ) i_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (acc_d),
    .exp_ackid (exp_ackid)
  );

  assign timer_tick = (state_q == ST_ERR_STOP) && !lreq_rcvd;

  rx_lreq_timer #(
    .LREQ_TIMEOUT (LREQ_TIMEOUT)
  ) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (pna_d),
    .tick  (timer_tick),
    .fatal (fatal_err)
  );

  // next-state and request decisions
  always_comb begin
    state_d = state_q;
    acc_d   = 1'b0;
    rty_d   = 1'b0;
    pna_d   = 1'b0;
    lresp_d = 1'b0;
    evt_d   = 1'b0;
    unique case (state_q)
      ST_NORMAL: begin
        if (link_violation || pkt_violation) begin
          state_d = ST_ERR_STOP;
          pna_d   = 1'b1;
          evt_d   = 1'b1;
        end else if (pkt_valid) begin
          if (buf_ok) begin
            acc_d = 1'b1;
          end else begin
            state_d = ST_RETRY_STOP;
            rty_d   = 1'b1;
          end
        end
      end
      ST_RETRY_STOP: begin
        if (link_violation) begin
          state_d = ST_ERR_STOP;
          pna_d   = 1'b1;
          evt_d   = 1'b1;
        end else if (rfr_rcvd) begin
          state_d = ST_NORMAL;
        end
      end
      ST_ERR_STOP: begin
        if (lreq_rcvd) begin
          state_d = ST_NORMAL;
          lresp_d = 1'b1;
        end
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
      acc_q   <= 1'b0;
      rty_q   <= 1'b0;
      pna_q   <= 1'b0;
      lresp_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
      rty_q   <= rty_d;
      pna_q   <= pna_d;
      lresp_q <= lresp_d;
      evt_q   <= evt_d;
    end
  end

  assign pkt_accept    = acc_q;
  assign send_retry    = rty_q;
  assign send_pna      = pna_q;
  assign send_lresp    = lresp_q;
  assign err_event     = evt_q;
  assign lresp_ackid   = exp_ackid;
  assign retry_stopped = (state_q == ST_RETRY_STOP);
  assign error_stopped = (state_q == ST_ERR_STOP);

  AST_ACCEPT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_accept |-> (lresp_ackid == $past(lresp_ackid) + ACKID_W'(1))); // R2
  AST_RETRY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_stopped) |-> send_retry); // R3
  AST_PNA_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_stopped) |-> (send_pna && err_event)); // R4
  AST_LRESP_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    send_lresp |-> (!error_stopped && $past(error_stopped))); // R6
  AST_FATAL_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal_err) |-> error_stopped); // R7
  AST_ACCEPT_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_accept |-> $past(!retry_stopped && !error_stopped)); // R8
  AST_EVENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> !err_event); // R10

endmodule

// File: tb/test_link_rx_recovery.sv
module test_link_rx_recovery;

  localparam int T = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pkt_valid, pkt_crc_err, pkt_bad_char, pkt_too_long;
  logic [5:0] pkt_ackid;
  logic [1:0] pkt_prio;
  logic [3:0] buf_avail;
  logic       cs_crc_err, idle_bad_char, cancel_by_rfr, ack_bad_id, ack_timeout;
  logic       rfr_rcvd, lreq_rcvd;
  logic       pkt_accept, send_retry, send_pna, send_lresp, err_event;
  logic       retry_stopped, error_stopped, fatal_err;
  logic [5:0] lresp_ackid;

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_rx_recovery #(.LREQ_TIMEOUT(T)) i_link_rx_recovery (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ackid(pkt_ackid),
    .pkt_prio(pkt_prio), .pkt_crc_err(pkt_crc_err), .pkt_bad_char(pkt_bad_char),
    .pkt_too_long(pkt_too_long), .buf_avail(buf_avail), .cs_crc_err(cs_crc_err),
    .idle_bad_char(idle_bad_char), .cancel_by_rfr(cancel_by_rfr),
    .ack_bad_id(ack_bad_id), .ack_timeout(ack_timeout), .rfr_rcvd(rfr_rcvd),
    .lreq_rcvd(lreq_rcvd), .pkt_accept(pkt_accept), .send_retry(send_retry),
    .send_pna(send_pna), .send_lresp(send_lresp), .lresp_ackid(lresp_ackid),
    .err_event(err_event), .retry_stopped(retry_stopped),
    .error_stopped(error_stopped), .fatal_err(fatal_err)
  );

  // behavioural reference model: 0 normal, 1 retry-stopped, 2 error-stopped
  int m_state, m_exp, m_wait, m_fatal;
  int m_acc, m_rty, m_pna, m_lresp, m_evt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_exp = 0; m_wait = 0; m_fatal = 0;
      m_acc = 0; m_rty = 0; m_pna = 0; m_lresp = 0; m_evt = 0;
    end else begin
      bit link_bad, pkt_bad;
      link_bad = cs_crc_err || idle_bad_char || cancel_by_rfr || ack_bad_id || ack_timeout;
      pkt_bad  = pkt_valid && (pkt_crc_err || pkt_bad_char || pkt_too_long || (int'(pkt_ackid) != m_exp));
      m_acc = 0; m_rty = 0; m_pna = 0; m_lresp = 0; m_evt = 0;
      if (m_state == 0) begin
        if (link_bad || pkt_bad) begin
          m_state = 2; m_pna = 1; m_evt = 1; m_wait = 0;
        end else if (pkt_valid) begin
          if (buf_avail[pkt_prio]) begin
            m_acc = 1; m_exp = (m_exp + 1) % 64;
          end else begin
            m_state = 1; m_rty = 1;
          end
        end
      end else if (m_state == 1) begin
        if (link_bad) begin
          m_state = 2; m_pna = 1; m_evt = 1; m_wait = 0;
        end else if (rfr_rcvd) begin
          m_state = 0;
        end
      end else begin
        if (lreq_rcvd) begin
          m_state = 0; m_lresp = 1;
        end else begin
          m_wait++;
          if (m_wait >= T) m_fatal = 1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare every output against the model on each falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pkt_accept", 32'(pkt_accept), 32'(m_acc));
      chk("R2 lresp_ackid", 32'(lresp_ackid), 32'(m_exp));
      chk("R3 send_retry", 32'(send_retry), 32'(m_rty));
      chk("R3 retry_stopped", 32'(retry_stopped), 32'(m_state == 1));
      chk("R4 send_pna", 32'(send_pna), 32'(m_pna));
      chk("R4 error_stopped", 32'(error_stopped), 32'(m_state == 2));
      chk("R6 send_lresp", 32'(send_lresp), 32'(m_lresp));
      chk("R7 fatal_err", 32'(fatal_err), 32'(m_fatal));
      chk("R10 err_event", 32'(err_event), 32'(m_evt));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic clear_in();
    pkt_valid = 0; pkt_ackid = 0; pkt_prio = 0; pkt_crc_err = 0; pkt_bad_char = 0;
    pkt_too_long = 0; buf_avail = 4'hF; cs_crc_err = 0; idle_bad_char = 0;
    cancel_by_rfr = 0; ack_bad_id = 0; ack_timeout = 0; rfr_rcvd = 0; lreq_rcvd = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic pkt(int id, int prio, logic [3:0] bufs);
    pkt_valid = 1; pkt_ackid = 6'(id); pkt_prio = 2'(prio); buf_avail = bufs;
    step();
  endtask

  task automatic do_reset();
    rst_n = 0;
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    clear_in();
    do_reset();
    // R1 reset state
    chk("R1 retry_stopped", 32'(retry_stopped), 0);
    chk("R1 error_stopped", 32'(error_stopped), 0);
    chk("R1 fatal_err", 32'(fatal_err), 0);
    chk("R1 lresp_ackid", 32'(lresp_ackid), 0);
    chk("R1 pulses", 32'({pkt_accept, send_retry, send_pna, send_lresp, err_event}), 0);

    // R2 accepts
    for (int i = 0; i < 3; i++) begin
      pkt(i, i, 4'hF);
      chk("R2 accept", 32'(pkt_accept), 1);
    end
    chk("R2 ackid after three", 32'(lresp_ackid), 3);

    // R3 buffer shortage on priority 2
    pkt(3, 2, 4'b1011);
    chk("R3 retry", 32'({send_retry, retry_stopped}), 3);
    // R8 packet discarded while retry-stopped
    pkt(3, 0, 4'hF);
    chk("R8 no accept", 32'({pkt_accept, send_retry}), 0);
    chk("R8 ackid kept", 32'(lresp_ackid), 3);
    step();
    chk("R3 still stopped", 32'(retry_stopped), 1);
    rfr_rcvd = 1; step();
    chk("R3 exit on rfr", 32'(retry_stopped), 0);

    // R4 wrong ackid with no buffer: error path wins
    pkt(5, 1, 4'h0);
    chk("R4 pna on bad ackid", 32'({send_pna, error_stopped, send_retry}), 6);
    // R9 second violation ignored, R8 packet discarded
    cs_crc_err = 1; pkt(3, 0, 4'hF);
    chk("R9 no second pna", 32'({send_pna, err_event}), 0);
    chk("R8 no accept in err", 32'(pkt_accept), 0);
    lreq_rcvd = 1; step();
    chk("R6 lresp", 32'({send_lresp, error_stopped}), 2);
    chk("R6 lresp ackid", 32'(lresp_ackid), 3);

    // R4 each packet error flag
    for (int k = 0; k < 3; k++) begin
      pkt_crc_err = (k == 0); pkt_bad_char = (k == 1); pkt_too_long = (k == 2);
      pkt(3, 0, 4'hF);
      chk("R4 packet flag", 32'({send_pna, error_stopped}), 3);
      lreq_rcvd = 1; step();
    end

    // R5 each link violation
    for (int k = 0; k < 5; k++) begin
      cs_crc_err = (k == 0); idle_bad_char = (k == 1); cancel_by_rfr = (k == 2);
      ack_bad_id = (k == 3); ack_timeout = (k == 4);
      step();
      chk("R5 link violation", 32'({send_pna, error_stopped, err_event}), 7);
      lreq_rcvd = 1; step();
      chk("R5 recovered", 32'(error_stopped), 0);
    end

    // R9 link violation beats rfr in retry-stopped
    pkt(3, 0, 4'h0);
    chk("R9 retry first", 32'(retry_stopped), 1);
    ack_timeout = 1; rfr_rcvd = 1; step();
    chk("R9 to error", 32'({send_pna, error_stopped, retry_stopped}), 6);

    // R7 timeout: lreq on edge T-1 after entry is still in time
    repeat (T - 2) step();
    chk("R7 not yet fatal", 32'(fatal_err), 0);
    lreq_rcvd = 1; step();
    chk("R7 late lreq ok", 32'({send_lresp, fatal_err}), 2);
    // no lreq at all
    idle_bad_char = 1; step();
    repeat (T - 1) step();
    chk("R7 fatal not before limit", 32'(fatal_err), 0);
    step();
    chk("R7 fatal at limit", 32'(fatal_err), 1);
    repeat (5) step();
    lreq_rcvd = 1; step();
    chk("R7 recover after fatal", 32'({send_lresp, error_stopped, fatal_err}), 5);

    // R1 again, then R2 ackid wrap
    do_reset();
    chk("R1 fatal cleared", 32'(fatal_err), 0);
    for (int i = 0; i < 64; i++) pkt(i, i % 4, 4'hF);
    chk("R2 ackid wrapped", 32'(lresp_ackid), 0);
    pkt(63, 0, 4'hF);
    chk("R4 stale ackid after wrap", 32'(error_stopped), 1);
    lreq_rcvd = 1; step();

    // random mix
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 45) begin
        pkt_valid = 1;
        pkt_ackid = ($urandom_range(0, 9) == 0) ? 6'($urandom) : 6'(m_exp);
        pkt_prio  = 2'($urandom);
        buf_avail = 4'hF & ~4'($urandom_range(0, 9) == 0 ? $urandom : 0);
        pkt_crc_err  = ($urandom_range(0, 40) == 0);
        pkt_bad_char = ($urandom_range(0, 40) == 0);
        pkt_too_long = ($urandom_range(0, 40) == 0);
      end
      cs_crc_err    = ($urandom_range(0, 120) == 0);
      idle_bad_char = ($urandom_range(0, 120) == 0);
      cancel_by_rfr = ($urandom_range(0, 120) == 0);
      ack_bad_id    = ($urandom_range(0, 120) == 0);
      ack_timeout   = ($urandom_range(0, 120) == 0);
      rfr_rcvd      = ($urandom_range(0, 7) == 0);
      lreq_rcvd     = ($urandom_range(0, 15) == 0);
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule